// File: doc/BRIEF.md
# Banked Three-State Output Enable Selector

This block decides, pin by pin, whether sixteen bidirectional pads are driven. The pads form two banks of eight. Each bank receives a pair of shared enable terms, produced elsewhere. Every pin carries a two-bit mode that chooses one of four behaviours: it never drives, it always drives, or it follows one of the two enable terms of its own bank.

For every pin the block produces a buffer enable and a three-state pad drive. It also returns the resolved pad level as input feedback. A pin that is not driven therefore works as an input, and one pin can serve as a plain output, an input, a bidirectional line, or a driver on a shared bus. The selection path is purely combinational, from the mode and term inputs to the buffer control. It contains no storage.

Top module: `tsoe_ctrl`

## Requirements
- R1: When a pin's mode field (bits [2i+1:2i] of `pin_mode_i` for pin i) is 2'b00, its enable `oe_o[i]` is 0 whatever the enable terms are.
- R2: When a pin's mode field is 2'b01, its enable is 1 whatever the enable terms are.
- R3: When a pin's mode field is 2'b10, its enable equals term A of its own bank. Term A of bank b is `bank_term_i[2b]`.
- R4: When a pin's mode field is 2'b11, its enable equals term B of its own bank. Term B of bank b is `bank_term_i[2b+1]`.
- R5: Pins 0 to 7 form bank 0 and use `bank_term_i[1:0]`. Pins 8 to 15 form bank 1 and use `bank_term_i[3:2]`. The terms of one bank have no effect on the enables of the other bank.
- R6: While `oe_o[i]` is 1, pad i carries `dout_i[i]`.
- R7: While `oe_o[i]` is 0, the block does not drive pad i, so an external driver sets the pad level and `din_o[i]` returns that level.
- R8: `din_o[i]` always equals the resolved level of pad i, including while the block itself drives the pad.
- R9: Enables, pad drive and feedback follow input changes combinationally, with no clock edge between a change and its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pin_mode_i | input | 32 | Two-bit mode per pin: 00 off, 01 on, 10 bank term A, 11 bank term B |
| bank_term_i | input | 4 | Shared enable terms: {bank1 B, bank1 A, bank0 B, bank0 A} |
| dout_i | input | 16 | Output data per pin |
| oe_o | output | 16 | Resolved buffer enable per pin |
| pad_io | inout | 16 | Three-state pads |
| din_o | output | 16 | Pad level fed back as input |

## Verification
All results are combinational, so each one is due in the same cycle as its stimulus. The driver applies a stimulus set just after a rising edge and queues the expected enables and feedback. The monitor pops and compares them at the following falling edge, half a period later, with no edge in between. Pads that neither the block nor the bench drives are masked out of the feedback comparison. The external driver is only switched on for pins whose expected enable is 0.

// File: rtl/tsoe_pkg.sv
package tsoe_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        PM_OFF    = 2'b00,
        PM_ON     = 2'b01,
        PM_TERM_A = 2'b10,
        PM_TERM_B = 2'b11
    } pin_mode_e;

    // Shared enable pair of one bank; term_a sits in the low bit.
    typedef struct packed {
        logic term_b;
        logic term_a;
    } bank_terms_t;

    function automatic logic pick_enable(pin_mode_e mode, bank_terms_t terms);
        logic en;
        case (mode)
            PM_OFF:    en = 1'b0;
            PM_ON:     en = 1'b1;
            PM_TERM_A: en = terms.term_a;
            default:   en = terms.term_b;
        endcase
        return en;
    endfunction

endpackage

// File: rtl/tsoe_bank.sv
module tsoe_bank
    import tsoe_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic [MODE_W*PINS-1:0] mode_i,
    input  bank_terms_t            terms_i,
    output logic [PINS-1:0]        oe_o
);

    generate
        for (genvar p = 0; p < PINS; p++) begin : g_pin
            pin_mode_e mode;
            assign mode    = pin_mode_e'(mode_i[MODE_W*p +: MODE_W]);
            assign oe_o[p] = pick_enable(mode, terms_i);

            always_comb begin
                if (!$isunknown({mode, terms_i, oe_o[p]})) begin
                    if (mode == PM_OFF)
                        assert_off_never_drives_R1: assert (oe_o[p] == 1'b0);
                    if (mode == PM_ON)
                        assert_on_always_drives_R2: assert (oe_o[p] == 1'b1);
                    if (mode == PM_TERM_A)
                        assert_follows_term_a_R3: assert (oe_o[p] == terms_i.term_a);
                    if (mode == PM_TERM_B)
                        assert_follows_term_b_R4: assert (oe_o[p] == terms_i.term_b);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/tsoe_pad.sv
module tsoe_pad (
    input  logic oe_i,
    input  logic dout_i,
    inout  wire  pad_io,
    output logic din_o
);

    assign pad_io = oe_i ? dout_i : 1'bz;
    assign din_o  = pad_io;

    always_comb begin
        if (!$isunknown({oe_i, dout_i}) && oe_i)
            assert_pad_carries_data_R6: assert (pad_io === dout_i);
    end

endmodule

// File: rtl/tsoe_ctrl.sv
module tsoe_ctrl
    import tsoe_pkg::*;
#(
    parameter int NPIN      = 16,
    parameter int BANK_PINS = 8
) (
    input  logic [MODE_W*NPIN-1:0]          pin_mode_i,
    input  logic [2*(NPIN/BANK_PINS)-1:0]   bank_term_i,
    input  logic [NPIN-1:0]                 dout_i,
    output logic [NPIN-1:0]                 oe_o,
    inout  wire  [NPIN-1:0]                 pad_io,
    output logic [NPIN-1:0]                 din_o
);

    localparam int NBANK  = NPIN / BANK_PINS;
    localparam int BMODEW = MODE_W * BANK_PINS;

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            tsoe_bank #(.PINS(BANK_PINS)) i_bank (
                .mode_i  (pin_mode_i[BMODEW*b +: BMODEW]),
                .terms_i (bank_terms_t'(bank_term_i[2*b +: 2])),
                .oe_o    (oe_o[BANK_PINS*b +: BANK_PINS])
            );
        end

        for (genvar i = 0; i < NPIN; i++) begin : g_pad
            tsoe_pad i_pad (
                .oe_i   (oe_o[i]),
                .dout_i (dout_i[i]),
                .pad_io (pad_io[i]),
                .din_o  (din_o[i])
            );
        end
    endgenerate

endmodule

// File: tb/test_tsoe_ctrl.sv
module test_tsoe_ctrl;

    localparam int NPIN = 16;

    typedef struct {
        logic [NPIN-1:0] oe;
        logic [NPIN-1:0] din;
        logic [NPIN-1:0] mask;
        string           tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [2*NPIN-1:0] mode = '0;
    logic [3:0]        terms = '0;
    logic [NPIN-1:0]   dout = '0;
    logic [NPIN-1:0]   ext_en = '0;
    logic [NPIN-1:0]   ext_val = '0;
    logic [NPIN-1:0]   oe;
    logic [NPIN-1:0]   din;
    wire  [NPIN-1:0]   pad;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    exp_t sb[$];

    always #5 clk = ~clk;

    for (genvar i = 0; i < NPIN; i++) begin : g_ext
        assign pad[i] = ext_en[i] ? ext_val[i] : 1'bz;
    end

    tsoe_ctrl i_tsoe_ctrl (
        .pin_mode_i  (mode),
        .bank_term_i (terms),
        .dout_i      (dout),
        .oe_o        (oe),
        .pad_io      (pad),
        .din_o       (din)
    );

    function automatic logic [NPIN-1:0] model_oe(logic [2*NPIN-1:0] m, logic [3:0] t);
        logic [NPIN-1:0] r;
        for (int i = 0; i < NPIN; i++) begin
            case (m[2*i +: 2])
                2'b00:   r[i] = 1'b0;
                2'b01:   r[i] = 1'b1;
                2'b10:   r[i] = t[2*(i/8)];
                default: r[i] = t[2*(i/8)+1];
            endcase
        end
        return r;
    endfunction

    // Driver: applies a stimulus after a rising edge and queues the expected results.
    task automatic apply(input logic [2*NPIN-1:0] m, input logic [3:0] t,
                         input logic [NPIN-1:0] d, input logic [NPIN-1:0] xval,
                         input logic [NPIN-1:0] xreq, input string tag);
        exp_t e;
        logic [NPIN-1:0] eo;
        @(posedge clk);
        #1;
        eo      = model_oe(m, t);
        mode    = m;
        terms   = t;
        dout    = d;
        ext_val = xval;
        ext_en  = xreq & ~eo;
        e.oe    = eo;
        e.mask  = eo | (xreq & ~eo);
        e.din   = (eo & d) | (~eo & xval);
        e.tag   = tag;
        sb.push_back(e);
    endtask

    // Monitor: half a period after each stimulus, compares against the queue head.
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_cmp++;
                if (oe !== e.oe) begin
                    n_bad++;
                    $display("FAIL %s oe: got %h expected %h", e.tag, oe, e.oe);
                end
                n_cmp++;
                if ((din & e.mask) !== (e.din & e.mask)) begin
                    n_bad++;
                    $display("FAIL %s din: got %h expected %h", e.tag, din & e.mask, e.din & e.mask);
                end
            end
        end
    end

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                rst = 1'b0;
                // R1: all pins off with every term high; bench drives all pads (R7)
                apply('0, 4'hF, 16'hFFFF, 16'hA5C3, 16'hFFFF, "R1/R7");
                // R2: all on, terms low; pads carry dout (R6, R8)
                apply({NPIN{2'b01}}, 4'h0, 16'h5A3C, 16'h0, 16'h0, "R2/R6/R8");
                // R3: all term A, bank0 A high, bank1 A low
                apply({NPIN{2'b10}}, 4'b0001, 16'hFFFF, 16'h1234, 16'hFFFF, "R3");
                apply({NPIN{2'b10}}, 4'b0100, 16'h0F0F, 16'h0000, 16'hFFFF, "R3");
                // R4: all term B
                apply({NPIN{2'b11}}, 4'b1000, 16'hC0DE, 16'hBEEF, 16'hFFFF, "R4");
                apply({NPIN{2'b11}}, 4'b0010, 16'hC0DE, 16'hBEEF, 16'hFFFF, "R4");
                // R5: bank0 on term A; toggling bank1 terms must not matter
                apply({{8{2'b00}}, {8{2'b10}}}, 4'b1100, 16'h00AA, 16'hFF00, 16'hFF00, "R5");
                apply({{8{2'b00}}, {8{2'b10}}}, 4'b0001, 16'h00AA, 16'hFF00, 16'hFF00, "R5");
                apply({{8{2'b11}}, {8{2'b00}}}, 4'b0011, 16'hAA00, 16'h00FF, 16'h00FF, "R5");
                // R9: consecutive changes, each checked without an intervening edge
                for (int k = 0; k < 200; k++) begin
                    apply({$urandom, $urandom}, 4'($urandom), 16'($urandom),
                          16'($urandom), 16'hFFFF, "R9/R8");
                end
                repeat (3) @(posedge clk);
                done = 1'b1;
            end
            begin
                repeat (5000) @(posedge clk);
                if (!done) begin
                    n_cmp++;
                    n_bad++;
                    $display("FAIL watchdog: got timeout expected completion");
                end
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule